// File: doc/BRIEF.md
# Bit-Masked GPIO Register Port

An eight-line general purpose I/O port placed behind a simple memory-mapped bus that moves one byte per access. Each line has a direction bit and an output value bit. Pad inputs pass through a two-stage synchroniser. The synchronised values go to the interrupt logic next to the port, and the bus can read them.

The low kilobyte of the address space is a data window. Address bits [9:2] act as a per-line select. A write there changes only the selected lines, and a read returns only the selected lines. Software can therefore set or clear a single pin with one bus write and no read-modify-write. The direction byte sits at offset 0x400. Every other offset reads as zero and ignores writes. Bus reads are combinational: `bus_rdata` is valid in the same cycle that `bus_en` is high.

Top module: `gpio_masked_port`

## Requirements
- R1: After reset all lines are inputs and the stored output values are zero, so `pad_oe` and `pad_out` are both 0x00.
- R2: A write to offset 0x400 loads the direction byte (bit n at 1 makes line n an output). `pad_oe` shows it from the next cycle, and a read of 0x400 returns it.
- R3: A write to an offset below 0x400 updates the output value of line n only where address bit n+2 is 1 and line n is an output. All other lines keep their value.
- R4: A read of an offset below 0x400 returns 0 in every bit n whose address bit n+2 is 0.
- R5: A data write to a line that is an input leaves no trace. When that line is later made an output, it drives the value stored before the write.
- R6: In a data read, a selected output line returns its stored output value and a selected input line returns its synchronised pad value.
- R7: `pin_sync` equals `pad_in` delayed by exactly two clock edges, and a data read sees the same delayed value.
- R8: Reads of any offset other than 0x400 and the data window (0x401 and above) return 0x00. Writes to those offsets change neither `pad_out` nor `pad_oe`.
- R9: `pad_out` is 0 on every line that is an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, combinational |
| pad_in | input | 8 | Raw pad inputs |
| pad_out | output | 8 | Output values to pads |
| pad_oe | output | 8 | Output enables to pads |
| pin_sync | output | 8 | Synchronised pad inputs for interrupt logic |

## Verification
A corrupted direction bit shows on `pad_oe` one cycle after the write that should have set it. It also changes what a later data read of that line returns. A stored output value that has been disturbed shows on `pad_out` at once if the line is an output. If the line is an input, the error stays hidden until the line is made an output, which is why the bench reads lines back after changing their direction. A fault in the synchroniser shows as `pin_sync` arriving one cycle early or late, and the bench checks the exact edge on which it changes.

// File: rtl/gpio_masked_port.sv
module gpio_masked_port #(
  parameter int ADDR_W = 12,
  parameter int NSYNC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        pad_in,
  output logic [7:0]        pad_out,
  output logic [7:0]        pad_oe,
  output logic [7:0]        pin_sync
);
  localparam logic [ADDR_W-1:0] DIR_OFS = ADDR_W'('h400);

  logic [7:0] dir_q, val_q;
  logic [7:0] sync_q [NSYNC];
  logic       in_window, at_dir;
  logic [7:0] sel, live, upd;

  assign in_window = (bus_addr >> 10) == '0;
  assign at_dir    = bus_addr == DIR_OFS;
  assign sel       = bus_addr[9:2];
  assign upd       = sel & dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      val_q <= '0;
    end else if (bus_en && bus_wr) begin
      if (at_dir)    dir_q <= bus_wdata;
      if (in_window) val_q <= (val_q & ~upd) | (bus_wdata & upd);
    end
  end

  genvar i;
  generate
    for (i = 0; i < NSYNC; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= '0;
        else        sync_q[i] <= (i == 0) ? pad_in : sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign pin_sync = sync_q[NSYNC-1];
  assign live     = (val_q & dir_q) | (pin_sync & ~dir_q);
  assign pad_oe   = dir_q;
  assign pad_out  = val_q & dir_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_wr) begin
      if (in_window)   bus_rdata = live & sel;
      else if (at_dir) bus_rdata = dir_q;
    end
  end
endmodule

module gpio_masked_port_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [7:0]        pad_in,
  input logic [7:0]        pad_out,
  input logic [7:0]        pad_oe,
  input logic [7:0]        pin_sync
);
  logic [1:0] age;
  logic       win, dirhit;
  assign win    = (bus_addr >> 10) == '0;
  assign dirhit = bus_addr == ADDR_W'('h400);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  // R1
  always_comb if (!rst_n) reset_state_chk: assert (pad_oe == '0 && pad_out == '0);

  // R2
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_wr && dirhit) |=> pad_oe == $past(bus_wdata));

  // R3
  masked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_wr && win) |=>
      ((pad_out & ~$past(bus_addr[9:2])) == ($past(pad_out) & ~$past(bus_addr[9:2]))));

  // R4
  read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_wr && win) |-> (bus_rdata & ~bus_addr[9:2]) == '0);

  // R8
  unimpl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_wr && !win && !dirhit) |=> $stable(pad_out) && $stable(pad_oe));

  // R8
  unimpl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_wr && !win && !dirhit) |-> bus_rdata == '0);

  // R7
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> pin_sync == $past(pad_in, 2));

  // R9
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);
endmodule

bind gpio_masked_port gpio_masked_port_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_gpio_masked_port.sv
module sim_gpio_masked_port;
  logic        clk = 0, rst_n = 0;
  logic        bus_en = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata, pad_in = '0, pad_out, pad_oe, pin_sync;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_dir = '0, m_val = '0;

  gpio_masked_port u0 (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(logic [11:0] a);
    if (a < 12'h400) return ((m_val & m_dir) | (pad_in & ~m_dir)) & a[9:2];
    if (a == 12'h400) return m_dir;
    return 8'h00;
  endfunction

  task automatic wr(logic [11:0] a, logic [7:0] d);
    @(negedge clk);
    bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_wr = 0;
    if (a == 12'h400) m_dir = d;
    else if (a < 12'h400) m_val = (m_val & ~(a[9:2] & m_dir)) | (d & a[9:2] & m_dir);
  endtask

  task automatic rd(logic [11:0] a, string req);
    @(negedge clk);
    bus_en = 1; bus_wr = 0; bus_addr = a;
    #2 chk(req, bus_rdata, exp_read(a));
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic set_pad(logic [7:0] p);
    @(negedge clk); pad_in = p;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 oe", pad_oe, 8'h00);
    chk("R1 out", pad_out, 8'h00);
    rst_n = 1;
    rd(12'h400, "R1 dir readback");
    rd(12'h3FC, "R1 data read");

    wr(12'h400, 8'hA5);
    chk("R2 pad_oe", pad_oe, 8'hA5);
    rd(12'h400, "R2 readback");

    wr(12'h3FC, 8'hFF);
    chk("R9 out only on outputs", pad_out, 8'hA5);
    wr(12'h004, 8'h00);
    chk("R3 single pin clear", pad_out, 8'hA4);
    wr(12'h080, 8'h00);
    chk("R3 pin5 clear", pad_out, 8'h84);
    rd(12'h084, "R4 masked read");

    wr(12'h008, 8'h02);
    wr(12'h400, 8'hA7);
    chk("R5 input write ignored", pad_out, 8'h84);

    @(negedge clk); pad_in = 8'h5A;
    @(negedge clk);
    chk("R7 one edge not yet", pin_sync, 8'h00);
    @(negedge clk);
    chk("R7 two edges", pin_sync, 8'h5A);
    rd(12'h3FC, "R6 mixed read");
    rd(12'h040, "R6 input pin masked");

    wr(12'h401, 8'hFF);
    wr(12'h800, 8'hFF);
    chk("R8 write ignored oe", pad_oe, 8'hA7);
    chk("R8 write ignored out", pad_out, 8'h84);
    rd(12'h404, "R8 read zero");
    rd(12'hFFC, "R8 read zero hi");

    for (int k = 0; k < 400; k++) begin
      int op = $urandom_range(0, 4);
      logic [11:0] a = 12'($urandom_range(0, 12'h3FF));
      case (op)
        0: wr(a, 8'($urandom));
        1: wr(12'h400, 8'($urandom));
        2: rd(a, "R6 random read");
        3: set_pad(8'($urandom));
        default: begin
          rd(12'($urandom_range(12'h401, 12'hFFF)), "R8 random");
          chk("R9 random", pad_out, m_val & m_dir);
          chk("R2 random", pad_oe, m_dir);
        end
      endcase
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
    $finish;
  end
endmodule